// File: doc/BRIEF.md
# Fault-first vector load controller

This block runs one vector load at a time. It accepts a base address, a requested element count and an element size code. It then fetches the elements one after another over a simple memory request/response channel, and stores each returned word in a local element buffer. When it finishes, it pulses `done_o` and presents the number of elements that were really loaded.

Only the first element is mandatory. If the memory reports a fault on element 0, the block raises `trap_o` together with `done_o` and reports a count of zero. A fault on any later element is not an error. The load stops at that element and the count reports how many elements completed. A consumer that needs every element checks the count against what it asked for.

The buffer contents can be read at any time through a combinational read port. Slots that a load did not reach keep their earlier values.

Top module: `ff_vload_ctrl`

## Requirements
- R1: `req_ready_o` is high only while the block is idle, including directly after reset. A request is taken when `req_valid_i` and `req_ready_o` are both high. `req_valid_i` has no effect while the block is busy.
- R2: Element i is fetched at address `base + (i << size_code)`, where size codes 0..3 stand for 1, 2, 4 and 8 bytes and the sum wraps at the address width. Elements are fetched in increasing i. After a request is accepted, `mem_req_valid_o` stays low until the response for it arrives.
- R3: While `mem_req_valid_o` is high and `mem_req_ready_i` is low, the request stays asserted with an unchanged address.
- R4: With no fault, the block writes element i's response data to buffer slot i for every requested element, and reports the requested count.
- R5: A fault on element 0 gives `trap_o` = 1 in the `done_o` cycle and a count of 0. No buffer slot is written.
- R6: A fault on element k > 0 ends the load with no trap and a count of k. No further request is issued, and buffer slots k and above keep their previous values.
- R7: A requested count of zero gives `done_o` in the cycle after acceptance, with count 0, no trap and no memory request.
- R8: `done_o` is a one-cycle pulse. `trap_o` is high only in a `done_o` cycle.
- R9: A response is taken only in the cycle where `mem_rsp_valid_i` is high, however many cycles it takes to arrive.
- R10: A requested count above `MAX_ELEMS` is handled as `MAX_ELEMS`.
- R11: After reset every buffer slot reads 0. `rd_data_o` shows slot `rd_idx_i` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Load request strobe |
| req_ready_o | output | 1 | Block idle, request can be taken |
| req_base_i | input | ADDR_W | Base address of element 0 |
| req_count_i | input | CNT_W | Requested element count |
| req_esize_i | input | 2 | Element size code (bytes = 1 << code) |
| mem_req_valid_o | output | 1 | Memory read request |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_addr_o | output | ADDR_W | Address of the requested element |
| mem_rsp_valid_i | input | 1 | Memory response present |
| mem_rsp_fault_i | input | 1 | Response reports a fault |
| mem_rsp_data_i | input | DATA_W | Response data |
| done_o | output | 1 | One-cycle end-of-load pulse |
| trap_o | output | 1 | First-element fault, valid with done_o |
| count_o | output | CNT_W | Elements actually loaded |
| rd_idx_i | input | IDX_W | Buffer read slot |
| rd_data_o | output | DATA_W | Buffer read data |

## Verification
Two events can land in the same response beat: the final requested element completing, and a fault that truncates the load. Directed runs place the fault exactly on the last requested element and also on element 0 of a one-element load, so completion and truncation compete in one cycle. The result is judged at the ports. The count must equal the fault index, `trap_o` is high only for index 0, and a buffer readback shows the faulting slot still holding its previous contents. Random runs mix grant stalls and response delays around the same rule.

// File: rtl/ffl_pkg.sv
package ffl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_FIN   = 2'd3
  } ffl_state_e;
endpackage

// File: rtl/ffl_addr_gen.sv
module ffl_addr_gen #(
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 3,
  parameter int ESIZE_W = 2
) (
  input  logic [ADDR_W-1:0]  base_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [ESIZE_W-1:0] esize_i,
  output logic [ADDR_W-1:0]  addr_o
);
  localparam int NSIZES = 1 << ESIZE_W;

  logic [ADDR_W-1:0] offs [NSIZES];

  for (genvar g = 0; g < NSIZES; g++) begin : g_offs
    assign offs[g] = ADDR_W'(idx_i) << g;
  end

  assign addr_o = base_i + offs[esize_i];
endmodule

// File: rtl/ffl_elem_buf.sv
module ffl_elem_buf #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int IDX_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] ent_q [DEPTH];
  logic [DEPTH-1:0]  wen;

  for (genvar g = 0; g < DEPTH; g++) begin : g_wen
    assign wen[g] = we_i && (wr_idx_i == IDX_W'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wen[i]) ent_q[i] <= wr_data_i;
      end
    end
  end

  assign rd_data_o = (int'(rd_idx_i) < DEPTH) ? ent_q[rd_idx_i] : '0;

  // R4: a write must target an existing slot
  always_comb begin
    if (rst_ni && we_i) begin
      p_wr_in_range_r4 : assert (int'(wr_idx_i) < DEPTH);
    end
  end
endmodule

// File: rtl/ffl_seq.sv
module ffl_seq
  import ffl_pkg::*;
#(
  parameter int MAX_ELEMS = 8,
  parameter int CNT_W     = 4,
  parameter int IDX_W     = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [CNT_W-1:0] req_count_i,
  output logic             req_ready_o,
  output logic             accept_o,
  output logic             mem_req_valid_o,
  input  logic             mem_req_ready_i,
  input  logic             rsp_valid_i,
  input  logic             rsp_fault_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             buf_we_o,
  output logic             done_o,
  output logic             trap_o,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_ELEMS);

  ffl_state_e       state_q;
  logic [CNT_W-1:0] idx_q, cnt_q, res_q, req_cnt;
  logic             trap_q, last_elem;

  assign req_cnt   = (req_count_i > MAX_CNT) ? MAX_CNT : req_count_i;
  assign last_elem = (idx_q + CNT_W'(1)) == cnt_q;

  assign req_ready_o     = state_q == ST_IDLE;
  assign accept_o        = req_ready_o && req_valid_i;
  assign mem_req_valid_o = state_q == ST_ISSUE;
  assign buf_we_o        = (state_q == ST_WAIT) && rsp_valid_i && !rsp_fault_i;
  assign done_o          = state_q == ST_FIN;
  assign trap_o          = done_o && trap_q;
  assign count_o         = res_q;
  assign idx_o           = idx_q[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
      res_q   <= '0;
      trap_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            cnt_q  <= req_cnt;
            idx_q  <= '0;
            trap_q <= 1'b0;
            res_q  <= '0;
            state_q <= (req_cnt == '0) ? ST_FIN : ST_ISSUE;
          end
        end
        ST_ISSUE: if (mem_req_ready_i) state_q <= ST_WAIT;
        ST_WAIT: begin
          if (rsp_valid_i) begin
            if (rsp_fault_i) begin
              // fault truncates; only element 0 is a trap
              trap_q  <= idx_q == '0;
              res_q   <= idx_q;
              state_q <= ST_FIN;
            end else if (last_elem) begin
              res_q   <= cnt_q;
              state_q <= ST_FIN;
            end else begin
              idx_q   <= idx_q + CNT_W'(1);
              state_q <= ST_ISSUE;
            end
          end
        end
        ST_FIN: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_one_outstanding_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && mem_req_ready_i |=> !mem_req_valid_o);

  p_done_pulse_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_trap_zero_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> done_o && count_o == '0);

  p_count_bound_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> count_o <= cnt_q);

  p_write_bound_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_we_o |-> idx_q < cnt_q);

  p_zero_done_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o && req_cnt == '0 |=> done_o && !mem_req_valid_o);

  p_busy_ignore_r1 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o && !done_o |=> !req_ready_o || $past(state_q) == ST_FIN);
endmodule

// File: rtl/ff_vload_ctrl.sv
module ff_vload_ctrl #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int MAX_ELEMS = 8,
  parameter int ESIZE_W   = 2,
  localparam int CNT_W    = $clog2(MAX_ELEMS + 1),
  localparam int IDX_W    = (MAX_ELEMS > 1) ? $clog2(MAX_ELEMS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [ADDR_W-1:0]  req_base_i,
  input  logic [CNT_W-1:0]   req_count_i,
  input  logic [ESIZE_W-1:0] req_esize_i,
  output logic               mem_req_valid_o,
  input  logic               mem_req_ready_i,
  output logic [ADDR_W-1:0]  mem_addr_o,
  input  logic               mem_rsp_valid_i,
  input  logic               mem_rsp_fault_i,
  input  logic [DATA_W-1:0]  mem_rsp_data_i,
  output logic               done_o,
  output logic               trap_o,
  output logic [CNT_W-1:0]   count_o,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output logic [DATA_W-1:0]  rd_data_o
);
  logic [ADDR_W-1:0]  base_q;
  logic [ESIZE_W-1:0] esize_q;
  logic               accept, buf_we;
  logic [IDX_W-1:0]   idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      esize_q <= '0;
    end else if (accept) begin
      base_q  <= req_base_i;
      esize_q <= req_esize_i;
    end
  end

  ffl_seq #(
    .MAX_ELEMS(MAX_ELEMS),
    .CNT_W    (CNT_W),
    .IDX_W    (IDX_W)
  ) u_seq (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .req_valid_i    (req_valid_i),
    .req_count_i    (req_count_i),
    .req_ready_o    (req_ready_o),
    .accept_o       (accept),
    .mem_req_valid_o(mem_req_valid_o),
    .mem_req_ready_i(mem_req_ready_i),
    .rsp_valid_i    (mem_rsp_valid_i),
    .rsp_fault_i    (mem_rsp_fault_i),
    .idx_o          (idx),
    .buf_we_o       (buf_we),
    .done_o         (done_o),
    .trap_o         (trap_o),
    .count_o        (count_o)
  );

  ffl_addr_gen #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W),
    .ESIZE_W(ESIZE_W)
  ) u_addr (
    .base_i (base_q),
    .idx_i  (idx),
    .esize_i(esize_q),
    .addr_o (mem_addr_o)
  );

  ffl_elem_buf #(
    .DATA_W(DATA_W),
    .DEPTH (MAX_ELEMS),
    .IDX_W (IDX_W)
  ) u_buf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (buf_we),
    .wr_idx_i (idx),
    .wr_data_i(mem_rsp_data_i),
    .rd_idx_i (rd_idx_i),
    .rd_data_o(rd_data_o)
  );

  p_req_hold_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_addr_o));

  p_fault_no_write_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rsp_valid_i && mem_rsp_fault_i |-> !buf_we);

  p_write_needs_rsp_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_we |-> mem_rsp_valid_i);
endmodule

// File: tb/ff_vload_ctrl_tb_top.sv
`timescale 1ns/1ps
module ff_vload_ctrl_tb_top;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int MAXE   = 8;
  localparam int CNT_W  = $clog2(MAXE + 1);
  localparam int IDX_W  = $clog2(MAXE);

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid_i = 1'b0;
  logic req_ready_o;
  logic [ADDR_W-1:0] req_base_i = '0;
  logic [CNT_W-1:0] req_count_i = '0;
  logic [1:0] req_esize_i = '0;
  logic mem_req_valid_o;
  logic mem_req_ready_i = 1'b0;
  logic [ADDR_W-1:0] mem_addr_o;
  logic mem_rsp_valid_i = 1'b0;
  logic mem_rsp_fault_i = 1'b0;
  logic [DATA_W-1:0] mem_rsp_data_i = '0;
  logic done_o, trap_o;
  logic [CNT_W-1:0] count_o;
  logic [IDX_W-1:0] rd_idx_i = '0;
  logic [DATA_W-1:0] rd_data_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [DATA_W-1:0] exp_buf [MAXE];

  always #2 clk_i = ~clk_i;

  ff_vload_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_ELEMS(MAXE)) dut_i (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_base_i, .req_count_i,
    .req_esize_i, .mem_req_valid_o, .mem_req_ready_i, .mem_addr_o,
    .mem_rsp_valid_i, .mem_rsp_fault_i, .mem_rsp_data_i, .done_o, .trap_o,
    .count_o, .rd_idx_i, .rd_data_o
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] elem_data(input logic [31:0] base, input int i);
    return base ^ (32'(i) * 32'h9E37_79B9) ^ 32'h5A00_0000;
  endfunction

  function automatic logic [ADDR_W-1:0] elem_addr(input logic [31:0] base, input int i,
                                                   input int es);
    return base + (32'(i) << es);
  endfunction

  task automatic read_all(input string req);
    for (int i = 0; i < MAXE; i++) begin
      rd_idx_i = IDX_W'(i);
      #0.5;
      check(rd_data_o == exp_buf[i], req, 64'(rd_data_o), 64'(exp_buf[i]));
    end
  endtask

  // one full load; fidx < 0 means no fault
  task automatic run_op(input logic [31:0] base, input int cnt, input int es,
                        input int fidx, input bit noise);
    int n, nreq, exp_cnt, e, guard;
    bit exp_trap, stalled, faulted;
    logic [ADDR_W-1:0] hold_addr;
    n = (cnt > MAXE) ? MAXE : cnt;
    faulted = (fidx >= 0) && (fidx < n);
    nreq = faulted ? fidx + 1 : n;
    exp_cnt = faulted ? fidx : n;
    exp_trap = faulted && (fidx == 0);
    e = 0; guard = 0; stalled = 0; hold_addr = '0;

    @(negedge clk_i);
    check(req_ready_o == 1'b1, "R1 ready when idle", 64'(req_ready_o), 64'd1);
    req_valid_i = 1'b1;
    req_base_i = base;
    req_count_i = CNT_W'(cnt);
    req_esize_i = 2'(es);
    @(negedge clk_i);
    req_valid_i = noise;
    if (noise) begin
      req_base_i = ~base;
      req_count_i = CNT_W'(1);
      req_esize_i = 2'(es + 1);
    end
    forever begin
      if (done_o) break;
      if (guard++ > 2000) begin
        check(1'b0, "R9 load never finished", 64'(guard), 64'd0);
        break;
      end
      check(!req_ready_o && !trap_o, "R1/R8 busy outputs", 64'({req_ready_o, trap_o}), 64'd0);
      if (mem_req_valid_o) begin
        if (stalled)
          check(mem_addr_o == hold_addr, "R3 address held while stalled",
                64'(mem_addr_o), 64'(hold_addr));
        else
          check(mem_addr_o == elem_addr(base, e, es), "R2 element address",
                64'(mem_addr_o), 64'(elem_addr(base, e, es)));
        check(e < nreq, "R6 no request after truncation", 64'(e), 64'(nreq));
        if ($urandom_range(0, 2) == 0) begin
          stalled = 1'b1;
          hold_addr = mem_addr_o;
          @(negedge clk_i);
          continue;
        end
        stalled = 1'b0;
        mem_req_ready_i = 1'b1;
        @(negedge clk_i);
        mem_req_ready_i = 1'b0;
        check(!mem_req_valid_o, "R2 single outstanding", 64'(mem_req_valid_o), 64'd0);
        repeat ($urandom_range(0, 3)) begin
          mem_rsp_data_i = $urandom;
          mem_rsp_fault_i = 1'($urandom);
          @(negedge clk_i);
        end
        mem_rsp_valid_i = 1'b1;
        mem_rsp_fault_i = (e == fidx);
        mem_rsp_data_i = elem_data(base, e);
        e++;
        @(negedge clk_i);
        mem_rsp_valid_i = 1'b0;
        mem_rsp_fault_i = 1'($urandom);
        mem_rsp_data_i = $urandom;
      end else begin
        @(negedge clk_i);
      end
    end
    req_valid_i = 1'b0;
    for (int i = 0; i < exp_cnt; i++) exp_buf[i] = elem_data(base, i);
    check(count_o == CNT_W'(exp_cnt), "R4/R6/R10 reported count", 64'(count_o), 64'(exp_cnt));
    check(trap_o == exp_trap, "R5/R6 trap flag", 64'(trap_o), 64'(exp_trap));
    check(e == nreq, "R2/R7 number of accesses", 64'(e), 64'(nreq));
    @(negedge clk_i);
    check(!done_o && !trap_o, "R8 done is a pulse", 64'({done_o, trap_o}), 64'd0);
    read_all("R4/R6 buffer contents");
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < MAXE; i++) exp_buf[i] = '0;
    repeat (3) @(negedge clk_i);
    check(req_ready_o && !done_o && !trap_o && !mem_req_valid_o, "R1 reset outputs",
          64'({req_ready_o, done_o, trap_o, mem_req_valid_o}), 64'h8);
    rst_ni = 1'b1;
    read_all("R11 buffer clear after reset");

    // R7 zero count
    run_op(32'h0000_1000, 0, 2, -1, 1'b0);
    // R4 full loads, every size code
    run_op(32'h0000_2000, 8, 0, -1, 1'b0);
    run_op(32'h0000_3000, 5, 1, -1, 1'b0);
    run_op(32'h0000_4000, 8, 2, -1, 1'b0);
    run_op(32'hFFFF_FFF0, 3, 3, -1, 1'b0);
    // R5 first element fault
    run_op(32'h0000_5000, 6, 2, 0, 1'b0);
    run_op(32'h0000_5800, 1, 2, 0, 1'b0);
    // R6 fault on last and middle element
    run_op(32'h0000_6000, 8, 2, 7, 1'b0);
    run_op(32'h0000_7000, 8, 1, 3, 1'b0);
    // R10 clamp, R1 request noise while busy
    run_op(32'h0000_8000, 15, 2, -1, 1'b1);
    run_op(32'h0000_9000, 4, 0, 2, 1'b1);

    for (int k = 0; k < 60; k++) begin
      int c, f;
      c = $urandom_range(0, 15);
      f = ($urandom_range(0, 2) == 0) ? -1 : $urandom_range(0, 8);
      run_op($urandom, c, $urandom_range(0, 3), f, 1'($urandom));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule